// File: doc/BRIEF.md
# PDM Microphone Decimating Front End

This block takes the bit stream of one or two pulse-density-modulated microphones that share one data wire and turns it into signed 24-bit PCM samples. It produces the microphone clock itself by dividing the system clock. It samples the data wire once in each half period of that clock. The sample taken in the high phase and the sample taken in the low phase belong to opposite channels, and a polarity input chooses which is which.

Each channel feeds a fourth-order integrator/comb decimator. The ratio is 64, 128 or 256 and can be selected at run time, so the microphone clock runs at the ratio times the output rate. Sample rates from 8 kHz to 48 kHz are reached by picking the system clock divider and the ratio together. The decimator result is scaled back to a Q23 fraction and multiplied by a Q23 gain in which 0x800000 is unity. It is then rounded and saturated to 24 bits, and one strobe per frame marks the result.

A host that works with a percentage boost B converts it to a gain of 0x800000*B/100 before driving the gain input, and uses unity when B is zero. Changing the ratio or the polarity, or turning capture on, flushes the filters and discards the first frame that follows.

Top module: `pdm_decim`

## Requirements
- R1: While reset is asserted and before the first frame, `pcm_vld_o` is 0, both PCM outputs are 0 and `pdm_clk_o` is low.
- R2: `pdm_clk_o` has a period of 2*HALF_DIV system cycles, with HALF_DIV cycles high and HALF_DIV cycles low.
- R3: `ratio_sel_i` value 0, 1 or 2 selects a decimation ratio of 64, 128 or 256 (64 shifted left by the value), and value 3 acts as 256. In steady state the frames are ratio*2*HALF_DIV system cycles apart.
- R4: At unity gain, in steady state, a channel whose bits have a density of ones d produces (2d-1)*2^23, rounded and saturated. All ones gives 0x7FFFFF, all zeros 0x800000, a 50 % pattern 0x000000 and a 75 % pattern 0x400000.
- R5: With `edge_swap_i`=0, the bit sampled while `pdm_clk_o` is high is the left channel and the bit sampled while it is low is the right channel. With `edge_swap_i`=1 the two are exchanged.
- R6: `chan_sel_i` 0 turns capture off and no strobe occurs. With 1 (left only), `pcm0_o` carries left and `pcm1_o` is 0. With 2 (right only), `pcm0_o` carries right and `pcm1_o` is 0. With 3 (stereo), `pcm0_o` carries left and `pcm1_o` carries right.
- R7: The output is floor(x*g/2^23 + 1/2), where x is the Q23 decimator value and g is `gain_i`, an unsigned Q23 value in which 0x800000 is unity.
- R8: Results above 0x7FFFFF saturate to 0x7FFFFF, and results below -0x800000 saturate to 0x800000.
- R9: A change of the effective ratio or of `edge_swap_i`, or `chan_sel_i` leaving 0, clears the filter state. The first frame after it is dropped, so the next strobe comes no earlier than (2*ratio-1) microphone clock periods later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdm_clk_o | output | 1 | Microphone clock, system clock divided by 2*HALF_DIV |
| pdm_data_i | input | 1 | Shared PDM data wire |
| ratio_sel_i | input | 2 | Decimation ratio select |
| chan_sel_i | input | 2 | Off, left, right or stereo |
| edge_swap_i | input | 1 | Exchanges which phase feeds the left channel |
| gain_i | input | 32 | Unsigned Q23 gain |
| pcm0_o | output | 24 | First output slot, signed |
| pcm1_o | output | 24 | Second output slot, signed, 0 in mono modes |
| pcm_vld_o | output | 1 | One-cycle strobe per output frame |

## Verification
The properties assume that every control input is synchronous to `clk_i`. The flush property only covers ratio changes between codes 0 to 2, because moving between 2 and 3 keeps the same effective ratio and does not flush. The bench changes controls only on the falling system edge. It then lets several frames pass before it scores any output, so the transient of the fourth-order filter never reaches a compared sample. Its microphone patterns repeat every four clock periods, and every ratio is a multiple of four, so the steady-state values come out exact.

// File: rtl/pdm_decim_pkg.sv
package pdm_decim_pkg;
  localparam int OUT_W     = 24;
  localparam int BASE_LOG2 = 6;   // smallest ratio is 2**BASE_LOG2
  localparam int MAX_SEL   = 2;
  localparam int ORDER     = 4;
  localparam int GAIN_W    = 32;
  localparam int FRAC      = OUT_W - 1;
  localparam int CNT_W     = BASE_LOG2 + MAX_SEL;
  localparam int ACC_W     = OUT_W + ORDER * CNT_W;

  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,
    CH_LEFT  = 2'd1,
    CH_RIGHT = 2'd2,
    CH_BOTH  = 2'd3
  } chan_e;

  // right shift that maps the full-scale decimator gain onto Q23
  function automatic int unsigned scale_shift(logic [1:0] sel);
    return ORDER * (BASE_LOG2 + int'(sel)) - FRAC;
  endfunction
endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pdm_clk_o,
  output logic smp_hi_o,
  output logic smp_lo_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pdm_clk_o <= 1'b0;
    end else if (last) begin
      cnt_q     <= '0;
      pdm_clk_o <= ~pdm_clk_o;
    end else begin
      cnt_q <= cnt_q + DW'(1);
    end
  end

  // sample in the final system cycle of each phase
  assign smp_hi_o = last &  pdm_clk_o;
  assign smp_lo_o = last & ~pdm_clk_o;
endmodule

// File: rtl/pdm_cic.sv
module pdm_cic #(
  parameter int ACC_W = 56,
  parameter int ORDER = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    smp_i,
  input  logic                    bit_i,
  input  logic                    dec_i,
  input  logic                    emit_i,
  output logic signed [ACC_W-1:0] comb_o,
  output logic                    vld_o
);
  logic signed [ACC_W-1:0] integ_q [ORDER];
  logic signed [ACC_W-1:0] dly_q   [ORDER];
  logic signed [ACC_W-1:0] diff    [ORDER+1];
  logic signed [ACC_W-1:0] step;

  assign step = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ORDER; k++) integ_q[k] <= '0;
    end else if (clr_i) begin
      for (int k = 0; k < ORDER; k++) integ_q[k] <= '0;
    end else if (smp_i) begin
      integ_q[0] <= integ_q[0] + step;
      for (int k = 1; k < ORDER; k++) integ_q[k] <= integ_q[k] + integ_q[k-1];
    end
  end

  always_comb begin
    diff[0] = integ_q[ORDER-1];
    for (int k = 0; k < ORDER; k++) diff[k+1] = diff[k] - dly_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ORDER; k++) dly_q[k] <= '0;
      comb_o <= '0;
      vld_o  <= 1'b0;
    end else if (clr_i) begin
      for (int k = 0; k < ORDER; k++) dly_q[k] <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= dec_i & emit_i;
      if (dec_i) begin
        for (int k = 0; k < ORDER; k++) dly_q[k] <= diff[k];
        comb_o <= diff[ORDER];
      end
    end
  end
endmodule

// File: rtl/pdm_gain_sat.sv
module pdm_gain_sat
  import pdm_decim_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    vld_i,
  input  logic signed [ACC_W-1:0] comb_i,
  input  logic [1:0]              sel_i,
  input  logic [GAIN_W-1:0]       gain_i,
  output logic [OUT_W-1:0]        pcm_o,
  output logic                    vld_o
);
  localparam int SC_W = OUT_W + 2;
  localparam int PW   = SC_W + GAIN_W + 1;
  localparam longint SAT_HI_I = (longint'(1) << FRAC) - 1;
  localparam logic signed [PW-1:0] SAT_HI = PW'(SAT_HI_I);
  localparam logic signed [PW-1:0] SAT_LO = PW'(-SAT_HI_I - 1);
  localparam logic signed [PW-1:0] HALF   = PW'(longint'(1) << (FRAC - 1));

  logic signed [SC_W-1:0] scaled;
  logic signed [PW-1:0]   scaled_x, gain_x, prod, quo;
  logic [OUT_W-1:0]       sat;

  always_comb begin
    scaled   = SC_W'(comb_i >>> scale_shift(sel_i));
    scaled_x = PW'(scaled);
    gain_x   = $signed(PW'(gain_i));
    prod     = scaled_x * gain_x;
    quo      = (prod + HALF) >>> FRAC;
    if (quo > SAT_HI)      sat = SAT_HI[OUT_W-1:0];
    else if (quo < SAT_LO) sat = SAT_LO[OUT_W-1:0];
    else                   sat = quo[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcm_o <= '0;
      vld_o <= 1'b0;
    end else if (clr_i) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) pcm_o <= sat;
    end
  end
endmodule

// File: rtl/pdm_decim.sv
module pdm_decim
  import pdm_decim_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              pdm_clk_o,
  input  logic              pdm_data_i,
  input  logic [1:0]        ratio_sel_i,
  input  logic [1:0]        chan_sel_i,
  input  logic              edge_swap_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [OUT_W-1:0]  pcm0_o,
  output logic [OUT_W-1:0]  pcm1_o,
  output logic              pcm_vld_o
);
  localparam int RL_W = CNT_W + 1;

  logic             smp_hi, smp_lo;
  logic [1:0]       ratio_eff, ratio_q;
  logic             pol_q, en, en_q, clr, drop_q, dec;
  logic [CNT_W-1:0] dcnt_q, rmax;
  logic [RL_W-1:0]  rlen;
  logic [1:0]       cic_vld, g_vld;
  logic [1:0][ACC_W-1:0] comb_w;
  logic [1:0][OUT_W-1:0] pcm_w;

  pdm_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pdm_clk_o(pdm_clk_o),
    .smp_hi_o (smp_hi),
    .smp_lo_o (smp_lo)
  );

  assign ratio_eff = (ratio_sel_i > 2'(MAX_SEL)) ? 2'(MAX_SEL) : ratio_sel_i;
  assign en        = (chan_sel_i != CH_OFF);
  // held clear while off; one-cycle clear on reconfiguration or enable
  assign clr       = !en || !en_q || (ratio_eff != ratio_q) || (edge_swap_i != pol_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      pol_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      ratio_q <= ratio_eff;
      pol_q   <= edge_swap_i;
      en_q    <= en;
    end
  end

  assign rlen = RL_W'(1) << (BASE_LOG2 + int'(ratio_q));
  assign rmax = CNT_W'(rlen - RL_W'(1));
  assign dec  = smp_lo && (dcnt_q == rmax) && !clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      drop_q <= 1'b1;
    end else if (clr) begin
      dcnt_q <= '0;
      drop_q <= 1'b1;
    end else begin
      if (smp_lo) dcnt_q <= (dcnt_q == rmax) ? '0 : dcnt_q + CNT_W'(1);
      if (dec)    drop_q <= 1'b0;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic smp;
    // channel 0 is left: high-phase bit unless swapped
    if (ch == 0) begin : g_left
      assign smp = pol_q ? smp_lo : smp_hi;
    end else begin : g_right
      assign smp = pol_q ? smp_hi : smp_lo;
    end

    pdm_cic #(.ACC_W(ACC_W), .ORDER(ORDER)) u_cic (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .smp_i (smp),
      .bit_i (pdm_data_i),
      .dec_i (dec),
      .emit_i(!drop_q),
      .comb_o(comb_w[ch]),
      .vld_o (cic_vld[ch])
    );

    pdm_gain_sat u_gain (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .vld_i (cic_vld[ch]),
      .comb_i(comb_w[ch]),
      .sel_i (ratio_q),
      .gain_i(gain_i),
      .pcm_o (pcm_w[ch]),
      .vld_o (g_vld[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcm0_o    <= '0;
      pcm1_o    <= '0;
      pcm_vld_o <= 1'b0;
    end else if (clr) begin
      pcm_vld_o <= 1'b0;
    end else begin
      pcm_vld_o <= &g_vld;
      if (&g_vld) begin
        pcm0_o <= (chan_sel_i == CH_RIGHT) ? pcm_w[1] : pcm_w[0];
        pcm1_o <= (chan_sel_i == CH_BOTH)  ? pcm_w[1] : '0;
      end
    end
  end
endmodule

// File: rtl/pdm_decim_chk.sv
module pdm_decim_chk #(
  parameter int HALF_DIV = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pdm_clk_o,
  input logic [1:0]  ratio_sel_i,
  input logic [1:0]  chan_sel_i,
  input logic        edge_swap_i,
  input logic [23:0] pcm1_o,
  input logic        pcm_vld_o
);
  localparam int SW = $clog2(HALF_DIV + 1) + 2;

  logic          prev_q;
  logic [SW-1:0] since_q;
  logic          tog;

  assign tog = (pdm_clk_o != prev_q);

  // reset value of all ones aligns the first phase with the later ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      since_q <= '1;
    end else begin
      prev_q  <= pdm_clk_o;
      since_q <= tog ? '0 : since_q + SW'(1);
    end
  end

  AST_CLK_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog |-> (since_q == SW'(HALF_DIV - 1))); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_vld_o |=> !pcm_vld_o); // R3

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_sel_i == 2'd0) |=> !pcm_vld_o); // R6

  AST_MONO_SLOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcm_vld_o && $past(chan_sel_i) != 2'd3) |-> (pcm1_o == 24'd0)); // R6

  AST_RECONF_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_swap_i != $past(edge_swap_i)) ||
     ((ratio_sel_i != $past(ratio_sel_i)) && ratio_sel_i != 2'd3 && $past(ratio_sel_i) != 2'd3))
    |=> !pcm_vld_o); // R9
endmodule

bind pdm_decim pdm_decim_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pdm_clk_o  (pdm_clk_o),
  .ratio_sel_i(ratio_sel_i),
  .chan_sel_i (chan_sel_i),
  .edge_swap_i(edge_swap_i),
  .pcm1_o     (pcm1_o),
  .pcm_vld_o  (pcm_vld_o)
);

// File: tb/tb_pdm_decim.sv
`timescale 1ns/1ps
module tb_pdm_decim;
  localparam int HD = 2;
  localparam int P  = 2 * HD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdm_clk, pdm_data = 1'b0;
  logic [1:0]  ratio_sel = 2'd0, chan_sel = 2'd3;
  logic        edge_swap = 1'b0;
  logic [31:0] gain = 32'h0080_0000;
  logic [23:0] pcm0, pcm1;
  logic        pcm_vld;

  always #2.5 clk = ~clk;

  pdm_decim #(.HALF_DIV(HD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pdm_clk_o(pdm_clk), .pdm_data_i(pdm_data),
    .ratio_sel_i(ratio_sel), .chan_sel_i(chan_sel), .edge_swap_i(edge_swap),
    .gain_i(gain), .pcm0_o(pcm0), .pcm1_o(pcm1), .pcm_vld_o(pcm_vld)
  );

  int checks = 0, errors = 0, cyc = 0;
  int frame_cnt = 0, last_vcyc = 0;
  int last_rise = 0, prev_rise = 0, last_fall = 0;
  logic [3:0] pat_a = 4'b0000, pat_b = 4'b0000;
  logic [1:0] idx = 2'd0;
  logic       pclk_prev = 1'b0;

  logic [23:0] exp0_q[$], exp1_q[$];
  int          gap_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc = cyc + 1;

  // microphone model: one bit per phase, pattern A in the high phase
  always @(negedge clk) begin
    if (pdm_clk && !pclk_prev) begin
      idx = idx + 2'd1;
      prev_rise = last_rise;
      last_rise = cyc;
    end
    if (!pdm_clk && pclk_prev) last_fall = cyc;
    pclk_prev = pdm_clk;
    pdm_data = pdm_clk ? pat_a[idx] : pat_b[idx];
  end

  // monitor: pops the scoreboard on every strobe while items are queued
  always @(negedge clk) begin
    if (pcm_vld) begin
      if (exp0_q.size() > 0) begin
        automatic logic [23:0] e0 = exp0_q.pop_front();
        automatic logic [23:0] e1 = exp1_q.pop_front();
        automatic int          g  = gap_q.pop_front();
        automatic string       t  = tag_q.pop_front();
        check(pcm0 == e0, {t, " slot0"}, pcm0, e0);
        check(pcm1 == e1, {t, " slot1"}, pcm1, e1);
        check(cyc - last_vcyc == g, {t, " R3 frame gap"}, cyc - last_vcyc, g);
      end
      last_vcyc = cyc;
      frame_cnt = frame_cnt + 1;
    end
  end

  task automatic run_case(input logic [3:0] pa, input logic [3:0] pb, input logic [1:0] rs,
                          input logic [1:0] cs, input logic sw, input logic [31:0] g,
                          input logic [23:0] e0, input logic [23:0] e1, input string tag);
    int start;
    int eff;
    @(negedge clk);
    pat_a = pa; pat_b = pb; ratio_sel = rs; chan_sel = cs; edge_swap = sw; gain = g;
    eff = (rs > 2'd2) ? 2 : int'(rs);
    start = frame_cnt;
    wait (frame_cnt >= start + 6);
    for (int i = 0; i < 3; i++) begin
      exp0_q.push_back(e0);
      exp1_q.push_back(e1);
      gap_q.push_back(P * (64 << eff));
      tag_q.push_back(tag);
    end
    wait (exp0_q.size() == 0);
  endtask

  task automatic restart_latency(input int ratio, input string tag);
    int t0, n, d, lo, hi;
    t0 = cyc;
    n  = frame_cnt;
    wait (frame_cnt > n);
    d  = last_vcyc - t0;
    lo = (2 * ratio - 1) * P;
    hi = 2 * ratio * P + 8;
    check(d >= lo && d <= hi, tag, d, lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 act=%0d exp=%0d", frame_cnt, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pcm_vld == 1'b0, "R1 vld in reset", pcm_vld, 0);
    check(pcm0 == 24'd0, "R1 pcm0 in reset", pcm0, 0);
    check(pcm1 == 24'd0, "R1 pcm1 in reset", pcm1, 0);
    check(pdm_clk == 1'b0, "R1 pdm clk in reset", pdm_clk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pdm_clk == 1'b0 && pcm_vld == 1'b0, "R1 after release", pdm_clk, 0);

    // R2: clock shape
    repeat (5 * P) @(negedge clk);
    check(last_rise - prev_rise == P, "R2 period", last_rise - prev_rise, P);
    wait (last_fall > last_rise);
    check(last_fall - last_rise == HD, "R2 high phase", last_fall - last_rise, HD);

    // R4 R5 R3 R8: full-scale channels, default polarity
    run_case(4'b1111, 4'b0000, 2'd0, 2'd3, 1'b0, 32'h0080_0000, 24'h7FFFFF, 24'h800000, "R4 R5 R8 ones/zeros");
    // R5: swapped edges
    run_case(4'b1111, 4'b0000, 2'd0, 2'd3, 1'b1, 32'h0080_0000, 24'h800000, 24'h7FFFFF, "R5 swap");
    // R4 R3: 75 % and 50 % density at each ratio
    run_case(4'b0111, 4'b0101, 2'd1, 2'd3, 1'b0, 32'h0080_0000, 24'h400000, 24'h000000, "R4 R3 ratio128");
    run_case(4'b0111, 4'b0101, 2'd2, 2'd3, 1'b0, 32'h0080_0000, 24'h400000, 24'h000000, "R4 R3 ratio256");
    run_case(4'b0111, 4'b0101, 2'd3, 2'd3, 1'b0, 32'h0080_0000, 24'h400000, 24'h000000, "R3 code3");
    // R6: mono modes
    run_case(4'b1111, 4'b0000, 2'd0, 2'd1, 1'b0, 32'h0080_0000, 24'h7FFFFF, 24'h000000, "R6 left only");
    run_case(4'b1111, 4'b0000, 2'd0, 2'd2, 1'b0, 32'h0080_0000, 24'h800000, 24'h000000, "R6 right only");
    // R7: gain and rounding
    run_case(4'b1111, 4'b0000, 2'd0, 2'd3, 1'b0, 32'h0040_0000, 24'h400000, 24'hC00000, "R7 half gain");
    run_case(4'b1111, 4'b0000, 2'd0, 2'd3, 1'b0, 32'h0000_0001, 24'h000001, 24'hFFFFFF, "R7 rounding");
    // R8: saturation under gain 2.0
    run_case(4'b0111, 4'b0000, 2'd0, 2'd3, 1'b0, 32'h0100_0000, 24'h7FFFFF, 24'h800000, "R8 saturation");

    // R6: capture off
    @(negedge clk);
    chan_sel = 2'd0;
    n = frame_cnt;
    repeat (3 * 256 * P) @(negedge clk);
    check(frame_cnt == n, "R6 off no strobe", frame_cnt - n, 0);

    // R9: re-enable drops the first frame
    gain = 32'h0080_0000;
    chan_sel = 2'd3;
    restart_latency(64, "R9 enable latency");
    repeat (3) begin
      n = frame_cnt;
      wait (frame_cnt > n);
    end
    // R9: ratio change
    @(negedge clk);
    ratio_sel = 2'd1;
    restart_latency(128, "R9 ratio change latency");
    // R9: polarity change
    @(negedge clk);
    edge_swap = 1'b1;
    restart_latency(128, "R9 polarity change latency");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule